// File: doc/BRIEF.md
# SDRAM Controller with Periodic Refresh

This block connects a simple host request port to one rank of a four-bank synchronous DRAM with a 64-bit data path. After reset it waits out a configurable power-up delay. It then brings the device up with a fixed command sequence and programs the mode register. After that it serves one host word per request. It opens the row with an activate command, issues the column read or write with auto-precharge, and waits out the row-cycle timing before it accepts the next request. Every row is closed again right after its access.

A free-running interval timer raises a refresh request at a parameterised rate. The default rate of 1560 cycles gives 4096 refreshes per 64 ms at 100 MHz. A pending refresh wins over waiting host traffic as soon as the access in flight has finished. Read data is captured a programmable CAS latency (2 or 3) after the read command. The byte masks are placed so that writes are masked in the command cycle and reads are masked two cycles before the data arrives.

Top module: `sdram_ctrl`

## Requirements
- R1: After reset the command pins show NOP for exactly PWRUP_CYC cycles. Next comes a precharge with A10 high. T_RP cycles later comes a refresh, then another refresh T_RC cycles after that. T_RC cycles after the second refresh comes a mode-register write. Its address is 0 except A[6:4], which holds the CAS latency (burst length 1 in A[2:0]=000, sequential order in A3=0).
- R2: While reset is held, chip select is high (deselect) and the clock enable is low.
- R3: An accepted request opens the row. Activate carries the bank (host_addr[21:20]) on BA and the row (host_addr[19:8]) on A. Exactly T_RCD cycles later comes the READ or WRITE. It carries the same bank, the column (host_addr[7:0]) on A[7:0], A10 high for auto-precharge, and all other A bits low.
- R4: In the WRITE cycle the data enable is high, the data output equals host_wdata and the byte mask equals the inverse of host_be. The data enable is low in every other cycle.
- R5: rd_valid is high for one cycle, CAS_LAT+1 cycles after the READ cycle. rd_data holds the value on sd_dq_in at the clock edge CAS_LAT cycles after the edge that sampled the READ.
- R6: For a read, the byte mask equals the inverse of host_be in the cycle that comes CAS_LAT-2 cycles after the READ cycle. Outside that cycle and the write cycle the mask is all ones.
- R7: Consecutive activates are at least T_RC cycles apart. An activate comes at least T_WR+T_RP cycles after a WRITE and at least T_RP cycles after a READ.
- R8: With no host traffic, refresh commands are exactly REF_INTERVAL cycles apart.
- R9: A refresh that falls due during an access is issued before the next waiting request is activated. Only NOPs appear for T_RC cycles after any refresh.
- R10: host_ready is high only while the controller is idle with no refresh pending. A request taken with host_valid and host_ready both high gives an activate in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| host_valid | input | 1 | Host request present |
| host_ready | output | 1 | Request is taken this cycle when valid |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 22 | {bank[1:0], row[11:0], column[7:0]} |
| host_wdata | input | 64 | Write data |
| host_be | input | 8 | Byte enables, one per byte lane, 1 = lane used |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 64 | Captured read data |
| sd_cke | output | 1 | Device clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | 12 | Row / column / mode address bus |
| sd_dqm | output | 8 | Byte masks, 1 = masked |
| sd_dq_out | output | 64 | Data toward the device |
| sd_dq_oe | output | 1 | Data output enable |
| sd_dq_in | input | 64 | Data from the device |

## Verification
A wrong wait-counter value shows up in the very next command. It puts the READ or WRITE at the wrong distance from its activate, or brings an activate or command too early after a refresh. Because the pins are registered, this is visible one cycle after the decision. A wrong latency pipeline moves rd_valid one cycle off, or captures the idle bus instead of the data. A misplaced read mask zeroes the wrong byte lanes in the returned word. A broken refresh timer or a broken priority changes the spacing between refreshes, or lets a queued activate go ahead of a refresh that is due. Both show within one refresh interval.

// File: rtl/sdr_pkg.sv
package sdr_pkg;

    // pin order {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MRS   = 4'b0000,
        CMD_REF   = 4'b0001,
        CMD_PRE   = 4'b0010,
        CMD_ACT   = 4'b0011,
        CMD_WR    = 4'b0100,
        CMD_RD    = 4'b0101,
        CMD_NOP   = 4'b0111,
        CMD_DESEL = 4'b1111
    } sdr_cmd_e;

    typedef enum logic [2:0] {
        ST_PWRUP,
        ST_INIT_REF1,
        ST_INIT_REF2,
        ST_INIT_MRS,
        ST_IDLE,
        ST_COLUMN
    } sdr_state_e;

endpackage

// File: rtl/sdr_refresh_timer.sv
module sdr_refresh_timer #(
    parameter int INTERVAL = 1560
) (
    input  logic clk,
    input  logic rst,
    input  logic ack,
    output logic pending
);
    localparam int CW = $clog2(INTERVAL + 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          pend_d, pend_q;

    always_comb begin
        cnt_d  = cnt_q + 1'b1;
        pend_d = pend_q;
        if (ack) begin
            pend_d = 1'b0;
        end
        if (cnt_q == CW'(INTERVAL - 1)) begin
            cnt_d  = '0;
            pend_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            pend_q <= pend_d;
        end
    end

    assign pending = pend_q;
endmodule

// File: rtl/sdr_rd_capture.sv
module sdr_rd_capture #(
    parameter int CAS_LAT = 2,
    parameter int DW      = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_issue,
    input  logic [DW-1:0] dq_in,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data
);
    logic [CAS_LAT-1:0] pipe_d, pipe_q;
    logic               vld_d, vld_q;
    logic [DW-1:0]      data_d, data_q;

    generate
        if (CAS_LAT == 1) begin : g_short
            always_comb pipe_d = rd_issue;
        end else begin : g_long
            always_comb pipe_d = {pipe_q[CAS_LAT-2:0], rd_issue};
        end
    endgenerate

    always_comb begin
        vld_d  = pipe_q[CAS_LAT-1];
        data_d = pipe_q[CAS_LAT-1] ? dq_in : data_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe_q <= '0;
            vld_q  <= 1'b0;
            data_q <= '0;
        end else begin
            pipe_q <= pipe_d;
            vld_q  <= vld_d;
            data_q <= data_d;
        end
    end

    assign rd_valid = vld_q;
    assign rd_data  = data_q;
endmodule

// File: rtl/sdram_ctrl.sv
module sdram_ctrl
    import sdr_pkg::*;
#(
    parameter int DW           = 64,
    parameter int BANK_W       = 2,
    parameter int ROW_W        = 12,
    parameter int COL_W        = 8,
    parameter int CAS_LAT      = 2,
    parameter int PWRUP_CYC    = 10000,
    parameter int REF_INTERVAL = 1560,
    parameter int T_RCD        = 2,
    parameter int T_RP         = 2,
    parameter int T_RC         = 7,
    parameter int T_WR         = 2,
    parameter int T_MRD        = 2,
    localparam int BE_W        = DW / 8,
    localparam int AW          = BANK_W + ROW_W + COL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_valid,
    output logic              host_ready,
    input  logic              host_write,
    input  logic [AW-1:0]     host_addr,
    input  logic [DW-1:0]     host_wdata,
    input  logic [BE_W-1:0]   host_be,
    output logic              rd_valid,
    output logic [DW-1:0]     rd_data,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BANK_W-1:0] sd_ba,
    output logic [ROW_W-1:0]  sd_addr,
    output logic [BE_W-1:0]   sd_dqm,
    output logic [DW-1:0]     sd_dq_out,
    output logic              sd_dq_oe,
    input  logic [DW-1:0]     sd_dq_in
);
    localparam int GAP_RC   = T_RC - T_RCD;
    localparam int GAP_RD0  = (GAP_RC > T_RP) ? GAP_RC : T_RP;
    localparam int RD_GAP   = (GAP_RD0 > CAS_LAT) ? GAP_RD0 : CAS_LAT;
    localparam int GAP_WR0  = T_WR + T_RP;
    localparam int WR_GAP   = (GAP_RC > GAP_WR0) ? GAP_RC : GAP_WR0;
    localparam int CNT_W    = $clog2(PWRUP_CYC + T_RC + RD_GAP + WR_GAP + 1);
    localparam bit MASK_LAG = (CAS_LAT > 2);
    localparam int AP_BIT   = 10;

    typedef struct packed {
        sdr_state_e           st;
        logic [CNT_W-1:0]     cnt;
        sdr_cmd_e             cmd;
        logic                 cke;
        logic [BANK_W-1:0]    ba;
        logic [ROW_W-1:0]     a;
        logic [BE_W-1:0]      dqm;
        logic                 oe;
        logic [DW-1:0]        dout;
        logic                 req_wr;
        logic [AW-1:0]        req_addr;
        logic [DW-1:0]        req_wdata;
        logic [BE_W-1:0]      req_be;
        logic                 mask_pend;
        logic [BE_W-1:0]      mask_val;
    } regs_t;

    regs_t r_q, r_d;
    logic  ref_pending;
    logic  ref_ack;
    logic  ready_int;

    sdr_refresh_timer #(
        .INTERVAL (REF_INTERVAL)
    ) u_refresh (
        .clk     (clk),
        .rst     (rst),
        .ack     (ref_ack),
        .pending (ref_pending)
    );

    sdr_rd_capture #(
        .CAS_LAT (CAS_LAT),
        .DW      (DW)
    ) u_capture (
        .clk      (clk),
        .rst      (rst),
        .rd_issue (r_q.cmd == CMD_RD),
        .dq_in    (sd_dq_in),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    assign ready_int = (r_q.st == ST_IDLE) && (r_q.cnt == '0) && !ref_pending;

    always_comb begin
        r_d       = r_q;
        r_d.cmd   = CMD_NOP;
        r_d.ba    = '0;
        r_d.a     = '0;
        r_d.dqm   = '1;
        r_d.oe    = 1'b0;
        r_d.dout  = '0;
        ref_ack   = 1'b0;

        if (r_q.mask_pend) begin
            r_d.dqm       = r_q.mask_val;
            r_d.mask_pend = 1'b0;
        end
        if (r_q.st == ST_PWRUP) begin
            r_d.cke = 1'b1;
        end

        if (r_q.cnt != '0) begin
            r_d.cnt = r_q.cnt - 1'b1;
        end else begin
            case (r_q.st)
                ST_PWRUP: begin
                    r_d.cmd       = CMD_PRE;
                    r_d.a[AP_BIT] = 1'b1;
                    r_d.cnt       = CNT_W'(T_RP - 1);
                    r_d.st        = ST_INIT_REF1;
                end
                ST_INIT_REF1: begin
                    r_d.cmd = CMD_REF;
                    r_d.cnt = CNT_W'(T_RC - 1);
                    r_d.st  = ST_INIT_REF2;
                end
                ST_INIT_REF2: begin
                    r_d.cmd = CMD_REF;
                    r_d.cnt = CNT_W'(T_RC - 1);
                    r_d.st  = ST_INIT_MRS;
                end
                ST_INIT_MRS: begin
                    r_d.cmd    = CMD_MRS;
                    r_d.a[6:4] = 3'(CAS_LAT);
                    r_d.cnt    = CNT_W'(T_MRD - 1);
                    r_d.st     = ST_IDLE;
                end
                ST_IDLE: begin
                    if (ref_pending) begin
                        r_d.cmd = CMD_REF;
                        r_d.cnt = CNT_W'(T_RC - 1);
                        ref_ack = 1'b1;
                    end else if (host_valid) begin
                        r_d.req_wr    = host_write;
                        r_d.req_addr  = host_addr;
                        r_d.req_wdata = host_wdata;
                        r_d.req_be    = host_be;
                        r_d.cmd       = CMD_ACT;
                        r_d.ba        = host_addr[AW-1 -: BANK_W];
                        r_d.a         = host_addr[COL_W +: ROW_W];
                        r_d.cnt       = CNT_W'(T_RCD - 1);
                        r_d.st        = ST_COLUMN;
                    end
                end
                ST_COLUMN: begin
                    r_d.ba             = r_q.req_addr[AW-1 -: BANK_W];
                    r_d.a[COL_W-1:0]   = r_q.req_addr[COL_W-1:0];
                    r_d.a[AP_BIT]      = 1'b1;
                    r_d.st             = ST_IDLE;
                    if (r_q.req_wr) begin
                        r_d.cmd  = CMD_WR;
                        r_d.oe   = 1'b1;
                        r_d.dout = r_q.req_wdata;
                        r_d.dqm  = ~r_q.req_be;
                        r_d.cnt  = CNT_W'(WR_GAP - 1);
                    end else begin
                        r_d.cmd = CMD_RD;
                        r_d.cnt = CNT_W'(RD_GAP - 1);
                        if (MASK_LAG) begin
                            r_d.mask_pend = 1'b1;
                            r_d.mask_val  = ~r_q.req_be;
                        end else begin
                            r_d.dqm = ~r_q.req_be;
                        end
                    end
                end
                default: r_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q           <= '0;
            r_q.st        <= ST_PWRUP;
            r_q.cnt       <= CNT_W'(PWRUP_CYC - 1);
            r_q.cmd       <= CMD_DESEL;
            r_q.dqm       <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign host_ready = ready_int;
    assign sd_cke     = r_q.cke;
    assign sd_cs_n    = r_q.cmd[3];
    assign sd_ras_n   = r_q.cmd[2];
    assign sd_cas_n   = r_q.cmd[1];
    assign sd_we_n    = r_q.cmd[0];
    assign sd_ba      = r_q.ba;
    assign sd_addr    = r_q.a;
    assign sd_dqm     = r_q.dqm;
    assign sd_dq_out  = r_q.dout;
    assign sd_dq_oe   = r_q.oe;
endmodule

// File: rtl/sdr_ctrl_checker.sv
module sdr_ctrl_checker #(
    parameter int T_RCD = 2,
    parameter int T_RP  = 2,
    parameter int T_RC  = 7,
    parameter int T_WR  = 2,
    parameter int ROW_W = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             host_valid,
    input logic             host_ready,
    input logic             sd_cs_n,
    input logic             sd_ras_n,
    input logic             sd_cas_n,
    input logic             sd_we_n,
    input logic [ROW_W-1:0] sd_addr,
    input logic             sd_dq_oe
);
    logic [3:0] cmd;
    logic       is_act, is_rd, is_wr, is_ref, is_nop;
    logic [7:0] since_act, since_rd, since_wr, since_ref;

    assign cmd    = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    assign is_act = (cmd == 4'b0011);
    assign is_rd  = (cmd == 4'b0101);
    assign is_wr  = (cmd == 4'b0100);
    assign is_ref = (cmd == 4'b0001);
    assign is_nop = (cmd == 4'b0111);

    always_ff @(posedge clk) begin
        if (rst) begin
            since_act <= '1;
            since_rd  <= '1;
            since_wr  <= '1;
            since_ref <= '1;
        end else begin
            since_act <= is_act ? 8'd1 : (since_act == '1 ? since_act : since_act + 8'd1);
            since_rd  <= is_rd  ? 8'd1 : (since_rd  == '1 ? since_rd  : since_rd  + 8'd1);
            since_wr  <= is_wr  ? 8'd1 : (since_wr  == '1 ? since_wr  : since_wr  + 8'd1);
            since_ref <= is_ref ? 8'd1 : (since_ref == '1 ? since_ref : since_ref + 8'd1);
        end
    end

    a_r3_rcd_exact: assert property (@(posedge clk) disable iff (rst)
        (is_rd || is_wr) |-> (since_act == 8'(T_RCD)));

    a_r3_auto_precharge: assert property (@(posedge clk) disable iff (rst)
        (is_rd || is_wr) |-> sd_addr[10]);

    a_r4_oe_only_write: assert property (@(posedge clk) disable iff (rst)
        sd_dq_oe |-> is_wr);

    a_r7_row_cycle: assert property (@(posedge clk) disable iff (rst)
        is_act |-> (since_act >= 8'(T_RC)));

    a_r7_write_recovery: assert property (@(posedge clk) disable iff (rst)
        is_act |-> (since_wr >= 8'(T_WR + T_RP)));

    a_r7_read_precharge: assert property (@(posedge clk) disable iff (rst)
        is_act |-> (since_rd >= 8'(T_RP)));

    a_r9_refresh_quiet: assert property (@(posedge clk) disable iff (rst)
        (since_ref < 8'(T_RC)) |-> is_nop);

    a_r10_accept_activates: assert property (@(posedge clk) disable iff (rst)
        (host_valid && host_ready) |=> is_act);
endmodule

bind sdram_ctrl sdr_ctrl_checker #(
    .T_RCD (T_RCD),
    .T_RP  (T_RP),
    .T_RC  (T_RC),
    .T_WR  (T_WR),
    .ROW_W (ROW_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .host_valid (host_valid),
    .host_ready (host_ready),
    .sd_cs_n    (sd_cs_n),
    .sd_ras_n   (sd_ras_n),
    .sd_cas_n   (sd_cas_n),
    .sd_we_n    (sd_we_n),
    .sd_addr    (sd_addr),
    .sd_dq_oe   (sd_dq_oe)
);

// File: tb/sim_sdram_ctrl.sv
module sim_sdram_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int CL   = 3;
    localparam int PWR  = 20;
    localparam int RINT = 300;
    localparam int TRCD = 2;
    localparam int TRP  = 2;
    localparam int TRC  = 7;
    localparam int TWR  = 2;
    localparam int TMRD = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_valid = 1'b0;
    logic        host_ready;
    logic        host_write = 1'b0;
    logic [21:0] host_addr = '0;
    logic [63:0] host_wdata = '0;
    logic [7:0]  host_be = '0;
    logic        rd_valid;
    logic [63:0] rd_data;
    logic        sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [1:0]  sd_ba;
    logic [11:0] sd_addr;
    logic [7:0]  sd_dqm;
    logic [63:0] sd_dq_out;
    logic        sd_dq_oe;
    logic [63:0] sd_dq_in = '0;

    sdram_ctrl #(
        .CAS_LAT (CL), .PWRUP_CYC (PWR), .REF_INTERVAL (RINT),
        .T_RCD (TRCD), .T_RP (TRP), .T_RC (TRC), .T_WR (TWR), .T_MRD (TMRD)
    ) u0 (
        .clk (clk), .rst (rst), .host_valid (host_valid), .host_ready (host_ready),
        .host_write (host_write), .host_addr (host_addr), .host_wdata (host_wdata),
        .host_be (host_be), .rd_valid (rd_valid), .rd_data (rd_data),
        .sd_cke (sd_cke), .sd_cs_n (sd_cs_n), .sd_ras_n (sd_ras_n),
        .sd_cas_n (sd_cas_n), .sd_we_n (sd_we_n), .sd_ba (sd_ba),
        .sd_addr (sd_addr), .sd_dqm (sd_dqm), .sd_dq_out (sd_dq_out),
        .sd_dq_oe (sd_dq_oe), .sd_dq_in (sd_dq_in)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int vectors = 0;
    int fails   = 0;
    int edge_n  = 0;
    int rel_edge = 0;

    // monitor records
    int act_cyc, prev_act_cyc, wr_cyc, rd_cyc, rdv_cyc, mrs_cyc, pre_cyc;
    int ref_cyc, prev_ref_cyc, ref_count = 0, oe_bad = 0;
    int init_refs [2];
    int wr_count = 0, rdv_count = 0, act_count = 0;
    logic [1:0]  act_ba, wr_ba;
    logic [11:0] act_row, wr_a, pre_a, mrs_a;
    logic [63:0] wr_dout, rdv_data;
    logic [7:0]  wr_dqm, mask_seen, mask_after;
    logic        wr_oe;

    // device model
    logic [63:0] mem [logic [21:0]];
    logic [11:0] open_row [4];
    int          rk = -1;
    logic [21:0] rkey;
    logic [7:0]  rmask;

    always @(posedge clk) begin
        edge_n <= edge_n + 1;
        if (!rst) begin
            logic [3:0] c;
            c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
            if (sd_dq_oe && c != 4'b0100) oe_bad++;
            if (rd_valid) begin
                rdv_cyc = edge_n; rdv_data = rd_data; rdv_count++;
            end
            case (c)
                4'b0011: begin
                    prev_act_cyc = act_cyc; act_cyc = edge_n; act_count++;
                    act_ba = sd_ba; act_row = sd_addr; open_row[sd_ba] = sd_addr;
                end
                4'b0100: begin
                    logic [21:0] k;
                    logic [63:0] old;
                    wr_cyc = edge_n; wr_ba = sd_ba; wr_a = sd_addr; wr_dout = sd_dq_out;
                    wr_dqm = sd_dqm; wr_oe = sd_dq_oe; wr_count++;
                    k = {sd_ba, open_row[sd_ba], sd_addr[7:0]};
                    old = mem.exists(k) ? mem[k] : 64'h0;
                    for (int b = 0; b < 8; b++)
                        if (!sd_dqm[b]) old[b*8 +: 8] = sd_dq_out[b*8 +: 8];
                    mem[k] = old;
                end
                4'b0101: begin
                    rd_cyc = edge_n; rk = 0; rkey = {sd_ba, open_row[sd_ba], sd_addr[7:0]};
                end
                4'b0001: begin
                    if (ref_count < 2) init_refs[ref_count] = edge_n;
                    prev_ref_cyc = ref_cyc; ref_cyc = edge_n; ref_count++;
                end
                4'b0010: begin pre_cyc = edge_n; pre_a = sd_addr; end
                4'b0000: begin mrs_cyc = edge_n; mrs_a = sd_addr; end
                default: ;
            endcase
            if (rk >= 0) begin
                if (rk == CL - 2) begin rmask = sd_dqm; mask_seen = sd_dqm; end
                if (rk == CL - 1) begin
                    logic [63:0] v;
                    mask_after = sd_dqm;
                    v = mem.exists(rkey) ? mem[rkey] : 64'h0;
                    for (int b = 0; b < 8; b++)
                        if (rmask[b]) v[b*8 +: 8] = 8'h00;
                    sd_dq_in <= v;
                end
                if (rk == CL) begin sd_dq_in <= '0; rk = -1; end
                else rk++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic issue(input bit wr, input logic [21:0] addr,
                         input logic [63:0] data, input logic [7:0] be, output int acc);
        @(negedge clk);
        host_valid = 1'b1; host_write = wr; host_addr = addr;
        host_wdata = data; host_be = be;
        while (!host_ready) @(negedge clk);
        @(negedge clk);
        acc = edge_n - 1;
        host_valid = 1'b0;
    endtask

    task automatic do_write(input logic [21:0] addr, input logic [63:0] data,
                            input logic [7:0] be);
        int acc, w0;
        w0 = wr_count;
        issue(1'b1, addr, data, be, acc);
        while (wr_count == w0) @(negedge clk);
        chk(act_cyc - acc == 1, "R10", "accept to activate", 64'(act_cyc - acc), 1);
        chk(act_ba == addr[21:20] && act_row == addr[19:8], "R3", "activate bank/row",
            {50'h0, act_ba, act_row}, {50'h0, addr[21:8]});
        chk(wr_cyc - act_cyc == TRCD, "R3", "activate to write", 64'(wr_cyc - act_cyc), 64'(TRCD));
        chk(wr_ba == addr[21:20] && wr_a == (12'h400 | {4'h0, addr[7:0]}), "R3",
            "write bank/column", {50'h0, wr_ba, wr_a}, {50'h0, addr[21:20], 12'h400 | {4'h0, addr[7:0]}});
        chk(wr_oe && wr_dout == data, "R4", "write data", wr_dout, data);
        chk(wr_dqm == ~be, "R4", "write mask", 64'(wr_dqm), 64'(~be));
    endtask

    task automatic do_read(input logic [21:0] addr, input logic [7:0] be,
                           input logic [63:0] exp);
        int acc, v0;
        v0 = rdv_count;
        issue(1'b0, addr, 64'h0, be, acc);
        while (rdv_count == v0) @(negedge clk);
        chk(rd_cyc - act_cyc == TRCD, "R3", "activate to read", 64'(rd_cyc - act_cyc), 64'(TRCD));
        chk(rdv_cyc - rd_cyc == CL + 1, "R5", "read latency", 64'(rdv_cyc - rd_cyc), 64'(CL + 1));
        chk(rdv_data == exp, "R5", "read data", rdv_data, exp);
        chk(mask_seen == ~be && mask_after == 8'hFF, "R6", "read mask timing",
            {48'h0, mask_seen, mask_after}, {48'h0, ~be, 8'hFF});
        @(negedge clk);
        chk(!rd_valid, "R5", "single valid pulse", 64'(rd_valid), 0);
    endtask

    task automatic t_reset_init();
        repeat (3) @(negedge clk);
        chk(sd_cs_n == 1'b1 && sd_cke == 1'b0, "R2", "pins in reset",
            {62'h0, sd_cs_n, sd_cke}, 64'h2);
        chk(!host_ready, "R10", "ready in reset", 64'(host_ready), 0);
        rel_edge = edge_n;
        rst = 1'b0;
        while (!host_ready) @(negedge clk);
        chk(pre_cyc - rel_edge == PWR, "R1", "power-up delay", 64'(pre_cyc - rel_edge), 64'(PWR));
        chk(pre_a[10], "R1", "precharge all", 64'(pre_a), 64'h400);
        chk(init_refs[0] - pre_cyc == TRP, "R1", "first refresh", 64'(init_refs[0] - pre_cyc), 64'(TRP));
        chk(init_refs[1] - init_refs[0] == TRC, "R1", "second refresh",
            64'(init_refs[1] - init_refs[0]), 64'(TRC));
        chk(mrs_cyc - init_refs[1] == TRC, "R1", "mode set spacing", 64'(mrs_cyc - init_refs[1]), 64'(TRC));
        chk(mrs_a == 12'(CL << 4), "R1", "mode value", 64'(mrs_a), 64'(CL << 4));
        chk(edge_n - mrs_cyc == TMRD - 1, "R10", "first ready", 64'(edge_n - mrs_cyc), 64'(TMRD - 1));
        chk(sd_cke == 1'b1, "R2", "cke after reset", 64'(sd_cke), 1);
    endtask

    task automatic t_write_read();
        do_write({2'd1, 12'h0A5, 8'h3C}, 64'h1122_3344_5566_7788, 8'hFF);
        do_read({2'd1, 12'h0A5, 8'h3C}, 8'hFF, 64'h1122_3344_5566_7788);
        do_write({2'd3, 12'hFFF, 8'hFF}, 64'hDEAD_BEEF_CAFE_F00D, 8'hFF);
        do_read({2'd3, 12'hFFF, 8'hFF}, 8'hFF, 64'hDEAD_BEEF_CAFE_F00D);
    endtask

    task automatic t_masks();
        do_write({2'd2, 12'h123, 8'h00}, 64'hAAAA_AAAA_AAAA_AAAA, 8'hFF);
        do_write({2'd2, 12'h123, 8'h00}, 64'h5555_5555_5555_5555, 8'h0F);
        do_read({2'd2, 12'h123, 8'h00}, 8'hFF, 64'hAAAA_AAAA_5555_5555);
        do_read({2'd2, 12'h123, 8'h00}, 8'h3C, 64'h0000_AAAA_5555_0000);
    endtask

    task automatic t_back_to_back();
        int a0, w0;
        do_write({2'd0, 12'h001, 8'h10}, 64'h0123_4567_89AB_CDEF, 8'hFF);
        a0 = act_cyc; w0 = wr_cyc;
        do_read({2'd0, 12'h002, 8'h10}, 8'hFF, 64'h0);
        chk(act_cyc - a0 >= TRC, "R7", "activate spacing", 64'(act_cyc - a0), 64'(TRC));
        chk(act_cyc - w0 >= TWR + TRP, "R7", "write recovery", 64'(act_cyc - w0), 64'(TWR + TRP));
        a0 = act_cyc; w0 = rd_cyc;
        do_read({2'd0, 12'h001, 8'h10}, 8'hFF, 64'h0123_4567_89AB_CDEF);
        chk(act_cyc - w0 >= TRP, "R7", "read precharge", 64'(act_cyc - w0), 64'(TRP));
        chk(act_cyc - a0 >= TRC, "R7", "activate spacing after read", 64'(act_cyc - a0), 64'(TRC));
    endtask

    task automatic t_refresh_idle();
        int c0;
        c0 = ref_count;
        while (ref_count < c0 + 3) @(negedge clk);
        chk(ref_cyc - prev_ref_cyc == RINT, "R8", "idle refresh spacing",
            64'(ref_cyc - prev_ref_cyc), 64'(RINT));
        chk(act_count > 0 && oe_bad == 0, "R4", "data enable outside writes", 64'(oe_bad), 0);
    endtask

    task automatic t_refresh_priority();
        int c0, acc, r_before;
        c0 = ref_count;
        while (ref_count == c0) @(negedge clk);
        repeat (RINT - 6) @(negedge clk);
        r_before = ref_count;
        do_write({2'd1, 12'h777, 8'h01}, 64'hFEED_FACE_0000_1111, 8'hFF);
        chk(ref_count == r_before, "R9", "no refresh yet", 64'(ref_count), 64'(r_before));
        do_read({2'd1, 12'h777, 8'h01}, 8'hFF, 64'hFEED_FACE_0000_1111);
        chk(ref_count == r_before + 1, "R9", "refresh served", 64'(ref_count), 64'(r_before + 1));
        chk(ref_cyc > wr_cyc && act_cyc - ref_cyc == TRC, "R9", "refresh before queued activate",
            64'(act_cyc - ref_cyc), 64'(TRC));
        acc = 0;
    endtask

    initial begin
        fork
            begin
                t_reset_init();
                t_write_read();
                t_masks();
                t_back_to_back();
                t_refresh_idle();
                t_refresh_priority();
            end
            begin
                repeat (100000) @(posedge clk);
                fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule